// File: doc/BRIEF.md
# Infrared Receive Run-Length Sampler

This block takes an already demodulated consumer-infrared signal, samples it once per programmable tick and turns each stretch of constant level into a run-length byte. A byte holds the level of the run (mark or gap) and its length in ticks. Finished bytes go into a small receive queue. A host reads the queue through a byte-wide register window that holds a status register, a receive data port and a control register.

A burst begins at the first tick that sees a mark. It ends when the gap after the last mark reaches a programmable length. At that point the gap byte is stored, the burst is closed and a timeout flag is raised. The host drains the queue in bursts: the first data-port read returns a header that gives the number of bytes waiting, and the reads after it return those bytes one by one. Two status flags, one for received data and one for timeout, are cleared by writing 1 to them. A level interrupt is raised when the enable bit is set and a flag is pending.

Top module: `irrx_sampler`

## Requirements
- R1: After reset the status register (offset 0x00) reads 0x00, the control register (offset 0x04) reads 0x50 (gap limit 20, 50 µs tick), irq is low, and a data-port (offset 0x01) read returns 0x00.
- R2: Each stored byte has bit 7 = 1 for a mark (ir_in high) or 0 for a gap, and bits 6:0 hold the run length in ticks. A burst starts at the first tick that samples a mark, and the gap that comes before it is not recorded.
- R3: A run longer than 127 ticks is stored as several consecutive bytes of the same level. Each byte holds 127 except the last, which holds the remainder.
- R4: When no burst read is in progress, a data-port read returns a header with bit 7 = 0 and bits 6:0 = the number of bytes queued. The next that many reads return the queued bytes, oldest first, and the read after them is a header again. With the queue empty the header is 0x00.
- R5: The queue holds 32 bytes. A byte produced while the queue is full is dropped, and the bytes already queued are unchanged.
- R6: Status bit 0 is set when a byte enters the queue and bit 1 is set on a timeout. Writing 1 to either bit clears it, and writing 0 leaves it unchanged. A set in the same cycle takes priority over a clear.
- R7: Control bits 7:2 give the gap limit in ticks. When a gap inside a burst reaches the limit, a gap byte of that length is stored, the burst closes and status bit 1 is set. A limit below 2 disables the timeout.
- R8: Status bit 7 is a read/write interrupt enable. irq is high exactly when bit 7 is set and status bit 0 or bit 1 is set.
- R9: Control bits 1:0 select the tick: 0 = 50 µs, 1 = 1 µs, 2 = 25 µs, 3 = 100 µs. The tick length is CLK_PER_US clock cycles times that figure.
- R10: Status bits 3:2 (transmit flags) always read 0. Offsets 0x02 and 0x03 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared level, 1 = mark |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data-port side effects happen at the clock edge |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is a full queue while a burst is still producing bytes. In that state the dropped bytes must leave the header count and the stored contents untouched, and the timeout flag must still be raised for a closing byte that was never stored. The bench reaches it by sending a burst of forty short alternating runs without reading. It then drains all 32 bytes and checks the order and the header that follows. A run longer than the 7-bit field, and a gap left open with the timeout disabled and then closed by re-enabling the limit, are the other states that take long, directed waveforms to reach.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
   localparam logic [2:0] OFS_STAT = 3'd0;
   localparam logic [2:0] OFS_DATA = 3'd1;
   localparam logic [2:0] OFS_TXC  = 3'd2;
   localparam logic [2:0] OFS_TXD  = 3'd3;
   localparam logic [2:0] OFS_CTRL = 3'd4;

   localparam int ST_RX  = 0;
   localparam int ST_TO  = 1;
   localparam int ST_IEN = 7;

   // tick length in microseconds for each resolution code
   function automatic int unsigned res_us(input logic [1:0] sel);
      case (sel)
         2'd0:    return 50;
         2'd1:    return 1;
         2'd2:    return 25;
         default: return 100;
      endcase
   endfunction
endpackage

// File: rtl/irrx_tick_gen.sv
module irrx_tick_gen #(
   parameter int CLK_PER_US = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] res_sel,
   output logic       tick
);
   import irrx_pkg::*;
   localparam int MAX_PER = CLK_PER_US * 100;
   localparam int CW      = $clog2(MAX_PER + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] per_m1;

   always_comb per_m1 = CW'(CLK_PER_US * res_us(res_sel) - 1);

   assign tick = (cnt_q >= per_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/irrx_run_enc.sv
module irrx_run_enc #(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 7,
   parameter int TO_W        = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ir_in,
   input  logic             tick,
   input  logic [TO_W-1:0]  to_lim,
   output logic             push,
   output logic [CNT_W:0]   push_data,
   output logic             to_evt
);
   localparam logic [CNT_W-1:0] RUN_MAX = '1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   smp;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= ir_in;
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], ir_in};
         end
      end
   endgenerate

   assign smp = sync_q[SYNC_STAGES-1];

   logic             active_q, lvl_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   nxt;
   logic             to_hit;
   logic [CNT_W-1:0] to_len;

   assign nxt    = {1'b0, cnt_q} + 1'b1;
   assign to_hit = (to_lim >= TO_W'(2)) && (nxt >= (CNT_W+1)'(to_lim));
   assign to_len = (cnt_q == RUN_MAX) ? RUN_MAX : nxt[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         lvl_q     <= 1'b0;
         cnt_q     <= '0;
         push      <= 1'b0;
         push_data <= '0;
         to_evt    <= 1'b0;
      end else begin
         push   <= 1'b0;
         to_evt <= 1'b0;
         if (tick) begin
            if (!active_q) begin
               if (smp) begin
                  active_q <= 1'b1;
                  lvl_q    <= 1'b1;
                  cnt_q    <= CNT_W'(1);
               end
            end else if (smp == lvl_q) begin
               if (!lvl_q && to_hit) begin
                  push      <= 1'b1;
                  push_data <= {1'b0, to_len};
                  to_evt    <= 1'b1;
                  active_q  <= 1'b0;
                  cnt_q     <= '0;
               end else if (cnt_q == RUN_MAX) begin
                  push      <= 1'b1;
                  push_data <= {lvl_q, RUN_MAX};
                  cnt_q     <= CNT_W'(1);
               end else begin
                  cnt_q <= nxt[CNT_W-1:0];
               end
            end else begin
               push      <= 1'b1;
               push_data <= {lvl_q, cnt_q};
               lvl_q     <= smp;
               cnt_q     <= CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 wdata,
   input  logic                         pop,
   output logic [W-1:0]                 head,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && (count != '0);
   assign head    = mem[rp_q];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         count <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/irrx_regs.sv
module irrx_regs #(
   parameter int          TO_W   = 6,
   parameter int          FCW    = 6,
   parameter int          HDR_W  = 7,
   parameter logic [TO_W-1:0] TO_DEF = 6'd20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [2:0]       reg_addr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   output logic             irq,
   output logic [1:0]       res_sel,
   output logic [TO_W-1:0]  to_lim,
   input  logic             push_ok,
   input  logic             to_evt,
   input  logic [FCW-1:0]   fifo_count,
   input  logic [7:0]       fifo_head,
   output logic             fifo_pop
);
   import irrx_pkg::*;

   logic             ien_q, rx_q, to_q;
   logic [7:0]       ctrl_q;
   logic [HDR_W-1:0] remain_q;
   logic             wr_stat, rd_data;

   assign wr_stat  = reg_wr && (reg_addr == OFS_STAT);
   assign rd_data  = reg_rd && (reg_addr == OFS_DATA);
   assign fifo_pop = rd_data && (remain_q != '0);
   assign res_sel  = ctrl_q[1:0];
   assign to_lim   = ctrl_q[7:2];
   assign irq      = ien_q && (rx_q || to_q);

   always_comb begin
      case (reg_addr)
         OFS_STAT: reg_rdata = {ien_q, 5'b0, to_q, rx_q};
         OFS_DATA: reg_rdata = (remain_q == '0) ? {1'b0, HDR_W'(fifo_count)} : fifo_head;
         OFS_CTRL: reg_rdata = ctrl_q;
         default:  reg_rdata = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q    <= 1'b0;
         rx_q     <= 1'b0;
         to_q     <= 1'b0;
         ctrl_q   <= {TO_DEF, 2'b00};
         remain_q <= '0;
      end else begin
         if (wr_stat) ien_q <= reg_wdata[ST_IEN];
         rx_q <= push_ok || (rx_q && !(wr_stat && reg_wdata[ST_RX]));
         to_q <= to_evt  || (to_q && !(wr_stat && reg_wdata[ST_TO]));
         if (reg_wr && reg_addr == OFS_CTRL) ctrl_q <= reg_wdata;
         if (rd_data) begin
            if (remain_q == '0) remain_q <= HDR_W'(fifo_count);
            else                remain_q <= remain_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/irrx_sampler.sv
module irrx_sampler #(
   parameter int CLK_PER_US  = 100,
   parameter int FIFO_DEPTH  = 32,
   parameter int SYNC_STAGES = 2,
   parameter int TO_DEFAULT  = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ir_in,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [2:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       irq
);
   localparam int CNT_W = 7;
   localparam int TO_W  = 6;
   localparam int FCW   = $clog2(FIFO_DEPTH + 1);

   generate
      if (FIFO_DEPTH < 2 || FIFO_DEPTH > 127 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two from 2 to 64");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (TO_DEFAULT < 0 || TO_DEFAULT > 63) begin : g_bad_to
         $error("TO_DEFAULT must fit the 6-bit gap limit field");
      end
      if (CLK_PER_US < 1) begin : g_bad_clk
         $error("CLK_PER_US must be at least 1");
      end
   endgenerate

   logic             tick;
   logic [1:0]       res_sel;
   logic [TO_W-1:0]  to_lim;
   logic             enc_push, enc_to;
   logic [CNT_W:0]   enc_data;
   logic             fifo_pop, fifo_full;
   logic [FCW-1:0]   fifo_count;
   logic [7:0]       fifo_head;
   logic             push_ok;

   assign push_ok = enc_push && !fifo_full;

   irrx_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk(clk), .rst_n(rst_n), .res_sel(res_sel), .tick(tick)
   );

   irrx_run_enc #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W), .TO_W(TO_W)) u_enc (
      .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .tick(tick), .to_lim(to_lim),
      .push(enc_push), .push_data(enc_data), .to_evt(enc_to)
   );

   irrx_fifo #(.W(CNT_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(enc_push), .wdata(enc_data), .pop(fifo_pop),
      .head(fifo_head), .count(fifo_count), .full(fifo_full)
   );

   irrx_regs #(.TO_W(TO_W), .FCW(FCW), .HDR_W(CNT_W), .TO_DEF(TO_W'(TO_DEFAULT))) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .res_sel(res_sel),
      .to_lim(to_lim), .push_ok(push_ok), .to_evt(enc_to), .fifo_count(fifo_count),
      .fifo_head(fifo_head), .fifo_pop(fifo_pop)
   );
endmodule

// File: rtl/irrx_sampler_chk.sv
module irrx_sampler_chk #(
   parameter int DEPTH = 32,
   parameter int FCW   = 6
) (
   input logic           clk,
   input logic           rst_n,
   input logic           reg_wr,
   input logic [2:0]     reg_addr,
   input logic [7:0]     reg_wdata,
   input logic [7:0]     reg_rdata,
   input logic           irq,
   input logic           enc_push,
   input logic [7:0]     enc_data,
   input logic           enc_to,
   input logic           fifo_pop,
   input logic           fifo_full,
   input logic [FCW-1:0] fifo_count
);
   a_r2_nonzero_len: assert property (@(posedge clk) disable iff (!rst_n)
      enc_push |-> (enc_data[6:0] != 7'd0));

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= FCW'(DEPTH));

   a_r5_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && !fifo_pop) |=> fifo_full);

   a_r4_empty_header: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 3'd1 && fifo_count == '0) |-> (reg_rdata == 8'h00));

   a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd0 && reg_wdata[1:0] == 2'b11 && !enc_push && !enc_to) |=> !irq);

   a_r8_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd0 && !reg_wdata[7]) |=> !irq);

   a_r10_tx_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 3'd0) |-> (reg_rdata[3:2] == 2'b00));
endmodule

bind irrx_sampler irrx_sampler_chk #(.DEPTH(FIFO_DEPTH), .FCW(FCW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .irq(irq), .enc_push(enc_push), .enc_data(enc_data),
   .enc_to(enc_to), .fifo_pop(fifo_pop), .fifo_full(fifo_full), .fifo_count(fifo_count)
);

// File: tb/test_irrx_sampler.sv
`timescale 1ns/1ps
module test_irrx_sampler;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ir_in = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq;

   int n_chk = 0, n_fail = 0;
   int per = 50;       // clock cycles per tick (CLK_PER_US = 1)
   bit finished = 0;

   always #2.5 clk = ~clk;

   irrx_sampler #(.CLK_PER_US(1)) i_irrx_sampler (
      .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic run(input logic lvl, input int ticks);
      @(negedge clk);
      ir_in = lvl;
      repeat (ticks * per - 1) @(negedge clk);
   endtask

   task automatic expect_burst(input string req, input int n, input logic [7:0] b0,
                               input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
      logic [7:0] d;
      logic [7:0] exp_b [4];
      exp_b[0] = b0; exp_b[1] = b1; exp_b[2] = b2; exp_b[3] = b3;
      rd(3'd1, d); check({req, " header"}, d, n);
      for (int i = 0; i < n; i++) begin
         rd(3'd1, d); check({req, " byte"}, d, exp_b[i]);
      end
   endtask

   task automatic drain();
      logic [7:0] d;
      int n;
      rd(3'd1, d); n = d;
      for (int i = 0; i < n; i++) rd(3'd1, d);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(3'd0, d); check("R1 status", d, 8'h00);
      rd(3'd4, d); check("R1 ctrl", d, 8'h50);
      check("R1 irq", irq, 0);
      rd(3'd1, d); check("R1 empty data", d, 8'h00);
   endtask

   task automatic t_basic();
      logic [7:0] d;
      run(1, 10); run(0, 5); run(1, 3); run(0, 25);
      rd(3'd0, d); check("R6 R7 flags", d, 8'h03);
      check("R8 irq gated off", irq, 0);
      expect_burst("R2 R7 R4", 4, 8'h8A, 8'h05, 8'h83, 8'h14);
      rd(3'd1, d); check("R4 header after drain", d, 8'h00);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      wr(3'd0, 8'h80); check("R8 irq on enable", irq, 1);
      wr(3'd0, 8'h81); rd(3'd0, d); check("R6 clear rx only", d, 8'h82);
      check("R8 irq timeout pending", irq, 1);
      wr(3'd0, 8'h82); rd(3'd0, d); check("R6 clear timeout", d, 8'h80);
      check("R8 irq no flags", irq, 0);
      wr(3'd0, 8'h0F); rd(3'd0, d); check("R6 clear all", d, 8'h00);
   endtask

   task automatic t_split();
      run(1, 300); run(0, 25);
      expect_burst("R3 split", 4, 8'hFF, 8'hFF, 8'hAE, 8'h14);
      wr(3'd0, 8'h0F);
   endtask

   task automatic t_full();
      logic [7:0] d;
      for (int i = 0; i < 20; i++) begin run(1, 2); run(0, 2); end
      run(0, 25);
      rd(3'd1, d); check("R5 header full", d, 8'h20);
      for (int i = 0; i < 32; i++) begin
         rd(3'd1, d); check("R5 queued byte", d, (i % 2 == 0) ? 8'h82 : 8'h02);
      end
      rd(3'd1, d); check("R5 header after drain", d, 8'h00);
      rd(3'd0, d); check("R5 R6 flags after drop", d, 8'h03);
      wr(3'd0, 8'h0F);
   endtask

   task automatic t_res();
      wr(3'd4, 8'h15); per = 1;
      run(1, 10); run(0, 10);
      expect_burst("R9 1us tick R7 limit 5", 2, 8'h8A, 8'h05, 8'h00, 8'h00);
      wr(3'd4, 8'h16); per = 25;
      run(1, 4); run(0, 8);
      expect_burst("R9 25us tick", 2, 8'h84, 8'h05, 8'h00, 8'h00);
      wr(3'd4, 8'h17); per = 100;
      run(1, 2); run(0, 8);
      expect_burst("R9 100us tick", 2, 8'h82, 8'h05, 8'h00, 8'h00);
      wr(3'd0, 8'h0F);
   endtask

   task automatic t_to_off();
      logic [7:0] d;
      wr(3'd4, 8'h01); per = 1;
      run(1, 3); run(0, 30);
      expect_burst("R7 timeout disabled", 1, 8'h83, 8'h00, 8'h00, 8'h00);
      rd(3'd0, d); check("R7 no timeout flag", d, 8'h01);
      wr(3'd4, 8'h15);
      repeat (5) @(negedge clk);
      rd(3'd0, d); check("R7 limit re-enabled closes", d, 8'h03);
      drain();
      wr(3'd0, 8'h0F);
   endtask

   task automatic t_tx();
      logic [7:0] d;
      wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
      rd(3'd2, d); check("R10 tx ctrl reads 0", d, 8'h00);
      rd(3'd3, d); check("R10 tx data reads 0", d, 8'h00);
      wr(3'd0, 8'h8C); rd(3'd0, d); check("R10 tx flags read 0", d, 8'h80);
      check("R10 R8 no irq from tx bits", irq, 0);
      wr(3'd0, 8'h00);
   endtask

   initial begin
      int cyc = 0;
      while (!finished && cyc < 150000) begin
         @(posedge clk); cyc++;
      end
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_basic();
      t_irq();
      t_split();
      t_full();
      t_res();
      t_to_off();
      t_tx();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule